// File: doc/BRIEF.md
# Bus Ownership Handover Arbiter

This block decides who drives a shared bus: the local processor, or one external master that asks for it. A master asks by pulling a request line low. The arbiter answers by pulling a grant line low, which promises that the processor will let go of the bus once its current cycle ends. Once that cycle has finished, the arbiter holds the processor off the bus and waits for the master to claim ownership by pulling an acknowledge line low. All three handshake lines are active low.

A separate flag tells the master model when a claim is legal. A claim is legal only when the grant is low, the address strobe is idle, the transfer acknowledge is idle and no other acknowledge is present. When the master drops its acknowledge, the processor takes the bus back, unless a new request is already waiting. Every input passes through a multi-flop synchronizer before any decision uses it. Arbitration between several masters is not part of this block.

Top module: `bus_handover_arbiter`

## Requirements
- R1: After reset, grant_n is 1, cpu_hold is 0 and take_ok is 0. The processor owns the bus.
- R2: When req_n goes low while the processor owns the bus, grant_n goes low on the third rising edge after the change (two synchronizer flops, then the state register), and not earlier. cpu_hold stays 0 while strobe_n is low and cyc_end is 0.
- R3: While granted and still requested, with ack_n high, cpu_hold rises and grant_n stays low once cyc_end is 1 or strobe_n is high.
- R4: If req_n returns high before ack_n goes low, grant_n returns to 1 and cpu_hold to 0. This holds whether or not the processor cycle has already ended.
- R5: When ack_n goes low while grant_n is low, grant_n returns to 1 and cpu_hold becomes 1. Both stay that way for as long as ack_n is held low.
- R6: take_ok is 1 exactly when grant_n is 0 and the synchronized strobe_n, xfer_ack_n and ack_n are all 1. It follows an input change after two rising edges.
- R7: When ack_n is released and req_n is high, the processor owns the bus again one clock after the release is synchronized (grant_n 1, cpu_hold 0). If req_n is low at that point, grant_n goes low and cpu_hold stays 1.
- R8: ack_n going low while the processor owns the bus and no request is pending has no effect: grant_n stays 1 and cpu_hold stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_n | input | 1 | Bus request from the external master, active low |
| ack_n | input | 1 | Ownership acknowledge from the external master, active low |
| strobe_n | input | 1 | Address strobe of the bus, active low |
| xfer_ack_n | input | 1 | Transfer acknowledge of the bus, active low |
| cyc_end | input | 1 | Processor reports that its current bus cycle has ended, active high |
| grant_n | output | 1 | Bus grant to the external master, active low |
| cpu_hold | output | 1 | Stops the processor from starting new bus cycles, active high |
| take_ok | output | 1 | Master may legally assert its acknowledge now |

## Verification
A wrong ownership state shows up directly as a wrong pair of grant_n and cpu_hold. The two are driven from the state register, so the error is visible one edge after the synchronized inputs that caused it. A bad eligibility term shows on take_ok two edges after the input changes, without waiting for the state register. The bench sweeps every static combination of the five inputs and checks the settled outputs. It also checks the exact edge at which grant_n, cpu_hold and take_ok change on request, release, withdrawal and re-request. An extra or missing synchronizer stage therefore shows as a one-cycle shift.

// File: rtl/bus_handover_pkg.sv
package bus_handover_pkg;

    typedef enum logic [1:0] {
        OWN_PROC   = 2'd0,
        OWN_GRANT  = 2'd1,
        OWN_PARK   = 2'd2,
        OWN_MASTER = 2'd3
    } owner_state_e;

    typedef struct packed {
        owner_state_e st;
        logic         grant_n;
        logic         hold;
    } owner_regs_t;

    localparam int unsigned IN_COUNT = 5;
    localparam int unsigned IX_REQ   = 0;
    localparam int unsigned IX_ACK   = 1;
    localparam int unsigned IX_STRB  = 2;
    localparam int unsigned IX_XFER  = 3;
    localparam int unsigned IX_CEND  = 4;

endpackage

// File: rtl/bh_sync.sv
module bh_sync #(
    parameter int unsigned WIDTH  = 5,
    parameter int unsigned STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] chain_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            logic [WIDTH-1:0] src;
            if (g == 0) begin : g_first
                assign src = din;
            end else begin : g_next
                assign src = chain_q[g-1];
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[g] <= RST_VAL;
                else        chain_q[g] <= src;
            end
        end
    endgenerate

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/bh_owner_fsm.sv
module bh_owner_fsm
    import bus_handover_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_s,
    input  logic ack_s,
    input  logic strobe_s,
    input  logic cyc_end_s,
    output logic grant_n,
    output logic hold
);
    owner_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            OWN_PROC: begin
                if (req_s) r_d.st = OWN_GRANT;
            end
            OWN_GRANT: begin
                if (ack_s)                        r_d.st = OWN_MASTER;
                else if (!req_s)                  r_d.st = OWN_PROC;
                else if (cyc_end_s || !strobe_s)  r_d.st = OWN_PARK;
            end
            OWN_PARK: begin
                if (ack_s)       r_d.st = OWN_MASTER;
                else if (!req_s) r_d.st = OWN_PROC;
            end
            OWN_MASTER: begin
                if (!ack_s) r_d.st = req_s ? OWN_PARK : OWN_PROC;
            end
            default: r_d.st = OWN_PROC;
        endcase
        r_d.grant_n = !((r_d.st == OWN_GRANT) || (r_d.st == OWN_PARK));
        r_d.hold    =  (r_d.st == OWN_PARK)  || (r_d.st == OWN_MASTER);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st      <= OWN_PROC;
            r_q.grant_n <= 1'b1;
            r_q.hold    <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign grant_n = r_q.grant_n;
    assign hold    = r_q.hold;

    // R3: processor cycle over while still requested -> parked under grant
    p_park_on_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == OWN_GRANT && req_s && !ack_s && (cyc_end_s || !strobe_s))
        |=> (!grant_n && hold));

    // R4: request withdrawn before acknowledge -> processor owns again
    p_withdraw_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant_n && !req_s && !ack_s) |=> (grant_n && !hold));

    // R5: acknowledge seen under grant -> grant released, processor held
    p_ack_takes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant_n && ack_s) |=> (grant_n && hold));

    // R5: hold kept while acknowledge stays
    p_hold_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_n && hold && ack_s) |=> (grant_n && hold));

    // R7: release with no request pending -> processor resumes next clock
    p_resume_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_n && hold && !ack_s && !req_s) |=> (grant_n && !hold));

    // R8: stray acknowledge while processor owns, no request -> nothing moves
    p_stray_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_n && !hold && !req_s) |=> (grant_n && !hold));
endmodule

// File: rtl/bh_take_check.sv
module bh_take_check (
    input  logic grant_n,
    input  logic strobe_s,
    input  logic xfer_s,
    input  logic ack_s,
    output logic take_ok
);
    always_comb begin
        take_ok = !grant_n && !strobe_s && !xfer_s && !ack_s;
    end
endmodule

// File: rtl/bus_handover_arbiter.sv
module bus_handover_arbiter
    import bus_handover_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_n,
    input  logic ack_n,
    input  logic strobe_n,
    input  logic xfer_ack_n,
    input  logic cyc_end,
    output logic grant_n,
    output logic cpu_hold,
    output logic take_ok
);
    localparam logic [IN_COUNT-1:0] IDLE_VAL = 5'b01111;

    logic [IN_COUNT-1:0] raw_in, sync_in;
    logic req_s, ack_s, strobe_s, xfer_s, cyc_end_s;

    assign raw_in[IX_REQ]  = req_n;
    assign raw_in[IX_ACK]  = ack_n;
    assign raw_in[IX_STRB] = strobe_n;
    assign raw_in[IX_XFER] = xfer_ack_n;
    assign raw_in[IX_CEND] = cyc_end;

    bh_sync #(.WIDTH(IN_COUNT), .STAGES(SYNC_STAGES), .RST_VAL(IDLE_VAL)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (raw_in),
        .dout  (sync_in)
    );

    assign req_s     = !sync_in[IX_REQ];
    assign ack_s     = !sync_in[IX_ACK];
    assign strobe_s  = !sync_in[IX_STRB];
    assign xfer_s    = !sync_in[IX_XFER];
    assign cyc_end_s =  sync_in[IX_CEND];

    bh_owner_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_s     (req_s),
        .ack_s     (ack_s),
        .strobe_s  (strobe_s),
        .cyc_end_s (cyc_end_s),
        .grant_n   (grant_n),
        .hold      (cpu_hold)
    );

    bh_take_check u_take (
        .grant_n  (grant_n),
        .strobe_s (strobe_s),
        .xfer_s   (xfer_s),
        .ack_s    (ack_s),
        .take_ok  (take_ok)
    );

    // R6: eligibility never while a master already owns the bus
    p_take_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        take_ok |-> (!cpu_hold || !grant_n) && !ack_s);

    // R1: first cycle out of reset has the processor as owner
    p_reset_owner_r1: assert property (@(posedge clk)
        !rst_n |=> (grant_n && !cpu_hold));
endmodule

// File: tb/bus_handover_arbiter_test.sv
module bus_handover_arbiter_test;
    localparam time CLK_PERIOD = 10;
    localparam int  WATCHDOG_CYCLES = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_n = 1'b1, ack_n = 1'b1, strobe_n = 1'b0, xfer_ack_n = 1'b1, cyc_end = 1'b0;
    logic grant_n, cpu_hold, take_ok;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    bus_handover_arbiter uut (
        .clk(clk), .rst_n(rst_n), .req_n(req_n), .ack_n(ack_n),
        .strobe_n(strobe_n), .xfer_ack_n(xfer_ack_n), .cyc_end(cyc_end),
        .grant_n(grant_n), .cpu_hold(cpu_hold), .take_ok(take_ok)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #(CLK_PERIOD/4);
    endtask

    task automatic at_neg();
        @(negedge clk);
    endtask

    task automatic do_reset();
        at_neg();
        rst_n = 1'b0;
        edges(2);
        at_neg();
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : stim
        // R1 reset state
        edges(1);
        chk("R1 grant_n", grant_n, 1'b1);
        chk("R1 cpu_hold", cpu_hold, 1'b0);
        chk("R1 take_ok", take_ok, 1'b0);
        do_reset();
        edges(2);
        chk("R1 grant_n after release", grant_n, 1'b1);
        chk("R1 cpu_hold after release", cpu_hold, 1'b0);

        // R2 latency of the grant
        at_neg(); req_n = 1'b0;
        edges(2);
        chk("R2 grant not yet", grant_n, 1'b1);
        edges(1);
        chk("R2 grant low", grant_n, 1'b0);
        chk("R2 no hold during cycle", cpu_hold, 1'b0);
        chk("R6 strobe active blocks take", take_ok, 1'b0);

        // R3 cycle ends, strobe idles
        at_neg(); cyc_end = 1'b1; strobe_n = 1'b1;
        edges(2);
        chk("R6 take after sync", take_ok, 1'b1);
        edges(1);
        at_neg(); cyc_end = 1'b0;
        chk("R3 hold", cpu_hold, 1'b1);
        chk("R3 grant kept", grant_n, 1'b0);

        // R6 transfer acknowledge blocks takeover
        at_neg(); xfer_ack_n = 1'b0;
        edges(2);
        chk("R6 xfer blocks take", take_ok, 1'b0);
        at_neg(); xfer_ack_n = 1'b1;
        edges(2);
        chk("R6 take back", take_ok, 1'b1);

        // R5 master acknowledges
        at_neg(); ack_n = 1'b0;
        edges(2);
        chk("R6 ack blocks take", take_ok, 1'b0);
        chk("R5 grant before state", grant_n, 1'b0);
        edges(1);
        chk("R5 grant released", grant_n, 1'b1);
        chk("R5 hold on", cpu_hold, 1'b1);
        at_neg(); req_n = 1'b1;
        edges(5);
        chk("R5 hold kept", cpu_hold, 1'b1);
        chk("R5 grant kept high", grant_n, 1'b1);

        // R7 release, no request
        at_neg(); ack_n = 1'b1;
        edges(2);
        chk("R7 hold until state", cpu_hold, 1'b1);
        edges(1);
        chk("R7 resume hold", cpu_hold, 1'b0);
        chk("R7 resume grant", grant_n, 1'b1);

        // R7 release with request pending
        at_neg(); req_n = 1'b0;
        edges(4);
        chk("R3 parked by idle strobe", cpu_hold, 1'b1);
        at_neg(); ack_n = 1'b0;
        edges(3);
        chk("R5 owned again", grant_n, 1'b1);
        at_neg(); ack_n = 1'b1;
        edges(3);
        chk("R7 regrant", grant_n, 1'b0);
        chk("R7 hold stays", cpu_hold, 1'b1);

        // R4 withdraw when parked
        at_neg(); req_n = 1'b1;
        edges(3);
        chk("R4 parked withdraw grant", grant_n, 1'b1);
        chk("R4 parked withdraw hold", cpu_hold, 1'b0);

        // R4 withdraw while cycle still running
        at_neg(); strobe_n = 1'b0; req_n = 1'b0;
        edges(3);
        chk("R4 granted", grant_n, 1'b0);
        chk("R4 no hold yet", cpu_hold, 1'b0);
        at_neg(); req_n = 1'b1;
        edges(3);
        chk("R4 running withdraw grant", grant_n, 1'b1);
        chk("R4 running withdraw hold", cpu_hold, 1'b0);

        // R8 stray acknowledge
        at_neg(); ack_n = 1'b0; strobe_n = 1'b1;
        edges(5);
        chk("R8 grant", grant_n, 1'b1);
        chk("R8 hold", cpu_hold, 1'b0);
        chk("R8 take", take_ok, 1'b0);
        at_neg(); ack_n = 1'b1;

        // Sweep of all held input combinations from reset
        for (int v = 0; v < 32; v++) begin
            logic br, bk, as_i, dt, ce;
            logic e_g, e_h, e_t;
            br = v[0]; bk = v[1]; as_i = v[2]; dt = v[3]; ce = v[4];
            at_neg();
            req_n = br; ack_n = bk; strobe_n = as_i; xfer_ack_n = dt; cyc_end = ce;
            do_reset();
            edges(8);
            if (br) begin e_g = 1'b1; e_h = 1'b0; end
            else if (!bk) begin e_g = 1'b1; e_h = 1'b1; end
            else if (as_i || ce) begin e_g = 1'b0; e_h = 1'b1; end
            else begin e_g = 1'b0; e_h = 1'b0; end
            e_t = !e_g && as_i && dt && bk;
            chk($sformatf("R2/R3/R5/R8 sweep %0d grant_n", v), grant_n, e_g);
            chk($sformatf("R3/R5 sweep %0d cpu_hold", v), cpu_hold, e_h);
            chk($sformatf("R6 sweep %0d take_ok", v), take_ok, e_t);
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule